// File: doc/BRIEF.md
# Dual-Bank Prioritized Interrupt Controller

This block collects 32 level interrupt lines and presents them to a processor as two independent requests: a normal request and a fast request. Every line first passes through a conditioning stage shared by both banks, which selects its polarity and whether it is latched. A 4-bit priority table is also shared between the banks. Each bank then keeps its own enable mask, its own latched pending state, its own priority threshold and its own acknowledge action.

Software reaches the block through a simple synchronous register bus. A write is one cycle with `wr_en` high. A read is one cycle with `rd_en` high, and `rdata` is valid in that same cycle. The service loop has three steps: poll a bank's masked status until it reads zero, read the bank's current-source register to learn which line to service, and read the bank's acknowledge register to drop that bank's latched events.

Byte address map:
- Normal bank: offset 0x000.
- Fast bank: offset 0x100.
- Shared select registers: offsets 0x200 and 0x204.
- Priority table: offset 0x300.

Top module: `intc_dual`

## Requirements
- R1: After reset, both request outputs are low, both enable masks read 0, both thresholds read 0xF, both current-source registers read 0, and every priority entry reads 0.
- R2: A write to bank offset 0x08 sets the enable bits where the data has ones. A write to bank offset 0x0C clears the enable bits where the data has ones. Reading 0x08 returns the enable mask, and reading 0x0C returns 0. Each bank has its own mask.
- R3: Line i is uninverted when bit i of the polarity register (0x200) is 1, and inverted when it is 0. The polarity register resets to 0. Bank offset 0x04 reads the conditioned lines before any enable masking.
- R4: Bank offset 0x00 reads the pending, enabled and eligible lines. A bank's request output is high exactly when that value is nonzero.
- R5: When bit i of the sticky register (0x204) is 1, a conditioned assertion of line i stays pending after the line drops. It is released only by a read of that bank's acknowledge offset 0x28, and that read leaves the other bank untouched.
- R6: When bit i of the sticky register is 0, line i is pending only while its conditioned level is 1.
- R7: Bank offset 0x20 returns the number of the qualifying line with the numerically smallest priority, choosing the lowest line number on a tie. It returns 0 when no line qualifies.
- R8: Bank offset 0x2C holds a 4-bit threshold. Lines whose priority is greater than the threshold are excluded from that bank's status, request and current-source result. The value 0xF admits every line.
- R9: The word at 0x300 + 4*i holds the 4-bit priority of line i, where 0 is the most urgent. Writes keep only data bits 3:0, and reads return the entry zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 10 | Byte address of the register access |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; side effects take place at the clock edge |
| rdata | output | 32 | Read data, valid in the strobe cycle |
| src_i | input | 32 | Interrupt lines, one per source |
| irq_o | output | 1 | Normal-bank request |
| fiq_o | output | 1 | Fast-bank request |

## Verification
A table of line patterns, paired with threshold settings, is run against a fixed priority assignment. The patterns cover several cases that each isolate one selection rule:
- A single line, to check the basic report.
- Two lines of different priority, where the higher line number must win.
- Two lines of equal priority, where the lower number must win.
- A line just above the threshold, which must be dropped.
- Line 0 alone qualifying, which separates a real result of 0 from the idle value of 0.

Directed cases cover the rest:
- Inverted and mixed polarity, seen on the raw view.
- The set and clear semantics of the enable writes.
- A one-cycle pulse on a sticky line and on a plain line, which shows latching against level following.
- Acknowledging one bank while the other still holds its event.

// File: rtl/intc_pkg.sv
package intc_pkg;
    parameter int NUM_SRC  = 32;
    parameter int PRIO_W   = 4;
    parameter int ADDR_W   = 10;
    parameter int DATA_W   = 32;
    parameter int NUM_BANK = 2;

    localparam int SRC_IDX_W = $clog2(NUM_SRC);

    typedef logic [NUM_SRC-1:0]   src_vec_t;
    typedef logic [PRIO_W-1:0]    prio_t;
    typedef prio_t [NUM_SRC-1:0]  prio_tbl_t;
    typedef logic [SRC_IDX_W-1:0] src_idx_t;

    // Register offsets inside one bank window.
    typedef enum logic [7:0] {
        REG_MASKED  = 8'h00,
        REG_RAW     = 8'h04,
        REG_EN_SET  = 8'h08,
        REG_EN_CLR  = 8'h0C,
        REG_CURRENT = 8'h20,
        REG_ACK     = 8'h28,
        REG_THRESH  = 8'h2C
    } bank_reg_e;

    // Offsets inside the shared select window.
    localparam logic [7:0] SH_POLARITY = 8'h00;
    localparam logic [7:0] SH_STICKY   = 8'h04;

    localparam prio_t PRIO_ACCEPT_ALL = '1;

    // Decoded per-bank register actions.
    typedef struct packed {
        logic set_we;
        logic clr_we;
        logic thr_we;
        logic ack_rd;
    } bank_ctl_t;

    function automatic logic prio_admitted(prio_t p, prio_t limit);
        return p <= limit;
    endfunction
endpackage

// File: rtl/intc_shared.sv
module intc_shared
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pol_we,
    input  logic              sticky_we,
    input  logic              prio_we,
    input  src_idx_t          prio_idx,
    input  logic [DATA_W-1:0] wdata,
    input  src_vec_t          src_i,
    output src_vec_t          cond,
    output src_vec_t          pol_q,
    output src_vec_t          sticky_q,
    output prio_tbl_t         prio_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pol_q    <= '0;
            sticky_q <= '0;
        end else begin
            if (pol_we)    pol_q    <= wdata[NUM_SRC-1:0];
            if (sticky_we) sticky_q <= wdata[NUM_SRC-1:0];
        end
    end

    // One priority register per line.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
        always_ff @(posedge clk) begin
            if (rst)                                    prio_q[i] <= '0;
            else if (prio_we && prio_idx == src_idx_t'(i)) prio_q[i] <= wdata[PRIO_W-1:0];
        end
    end

    // A set polarity bit passes the line through; a clear bit inverts it.
    assign cond = ~(src_i ^ pol_q);

    p_prio_write_r9: assert property (@(posedge clk) disable iff (rst)
        prio_we |=> prio_q[$past(prio_idx)] == $past(wdata[PRIO_W-1:0]));
endmodule

// File: rtl/intc_pick.sv
module intc_pick
    import intc_pkg::*;
(
    input  src_vec_t  qual,
    input  prio_tbl_t prio,
    output logic      found,
    output src_idx_t  idx
);
    prio_t best;

    // A strict "less than" keeps the lowest line number on equal priority.
    always_comb begin
        found = 1'b0;
        best  = '1;
        idx   = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (qual[i] && (!found || prio[i] < best)) begin
                found = 1'b1;
                best  = prio[i];
                idx   = src_idx_t'(i);
            end
        end
    end
endmodule

// File: rtl/intc_bank.sv
module intc_bank
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bank_ctl_t         ctl,
    input  logic [DATA_W-1:0] wdata,
    input  src_vec_t          cond,
    input  src_vec_t          sticky,
    input  prio_tbl_t         prio,
    output src_vec_t          en_q,
    output prio_t             thr_q,
    output src_vec_t          masked,
    output src_idx_t          cur,
    output logic              req
);
    src_vec_t latch_q;
    src_vec_t pend;
    src_vec_t elig;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            thr_q   <= PRIO_ACCEPT_ALL;
            latch_q <= '0;
        end else begin
            if (ctl.set_we)      en_q <= en_q | wdata[NUM_SRC-1:0];
            else if (ctl.clr_we) en_q <= en_q & ~wdata[NUM_SRC-1:0];
            if (ctl.thr_we)      thr_q <= wdata[PRIO_W-1:0];
            latch_q <= ctl.ack_rd ? '0 : (latch_q | (cond & sticky));
        end
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
        assign elig[i] = prio_admitted(prio[i], thr_q);
    end

    assign pend   = (latch_q & sticky) | cond;
    assign masked = pend & en_q & elig;

    intc_pick u_pick (
        .qual  (masked),
        .prio  (prio),
        .found (req),
        .idx   (cur)
    );

    p_en_set_r2: assert property (@(posedge clk) disable iff (rst)
        ctl.set_we |=> (en_q & $past(wdata[NUM_SRC-1:0])) == $past(wdata[NUM_SRC-1:0]));
    p_en_clr_r2: assert property (@(posedge clk) disable iff (rst)
        (ctl.clr_we && !ctl.set_we) |=> (en_q & $past(wdata[NUM_SRC-1:0])) == '0);
    p_ack_release_r5: assert property (@(posedge clk) disable iff (rst)
        ctl.ack_rd |=> latch_q == '0);
    p_cur_qualifies_r7: assert property (@(posedge clk) disable iff (rst)
        req |-> masked[cur]);
    p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
        !req |-> cur == '0);
    p_cur_threshold_r8: assert property (@(posedge clk) disable iff (rst)
        req |-> prio[cur] <= thr_q);
endmodule

// File: rtl/intc_dual.sv
module intc_dual
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    input  logic [NUM_SRC-1:0] src_i,
    output logic              irq_o,
    output logic              fiq_o
);
    logic [7:0] ofs;
    logic       in_shared;
    logic       bank_sel;
    logic       prio_hit;
    src_idx_t   prio_idx;
    logic       pol_we, sticky_we, prio_we;

    bank_ctl_t  ctl     [NUM_BANK];
    src_vec_t   en_q    [NUM_BANK];
    prio_t      thr_q   [NUM_BANK];
    src_vec_t   masked  [NUM_BANK];
    src_idx_t   cur     [NUM_BANK];
    logic       req     [NUM_BANK];

    src_vec_t   cond, pol_q, sticky_q;
    prio_tbl_t  prio_q;

    assign ofs       = addr[7:0];
    assign in_shared = addr[9];
    assign bank_sel  = addr[8];
    assign prio_idx  = addr[2 +: SRC_IDX_W];
    assign prio_hit  = in_shared && bank_sel && (int'(addr[7:2]) < NUM_SRC) && (addr[1:0] == 2'b00);
    assign pol_we    = wr_en && in_shared && !bank_sel && ofs == SH_POLARITY;
    assign sticky_we = wr_en && in_shared && !bank_sel && ofs == SH_STICKY;
    assign prio_we   = wr_en && prio_hit;

    always_comb begin
        for (int b = 0; b < NUM_BANK; b++) begin
            ctl[b].set_we = wr_en && !in_shared && (bank_sel == 1'(b)) && ofs == REG_EN_SET;
            ctl[b].clr_we = wr_en && !in_shared && (bank_sel == 1'(b)) && ofs == REG_EN_CLR;
            ctl[b].thr_we = wr_en && !in_shared && (bank_sel == 1'(b)) && ofs == REG_THRESH;
            ctl[b].ack_rd = rd_en && !in_shared && (bank_sel == 1'(b)) && ofs == REG_ACK;
        end
    end

    intc_shared u_shared (
        .clk       (clk),
        .rst       (rst),
        .pol_we    (pol_we),
        .sticky_we (sticky_we),
        .prio_we   (prio_we),
        .prio_idx  (prio_idx),
        .wdata     (wdata),
        .src_i     (src_i),
        .cond      (cond),
        .pol_q     (pol_q),
        .sticky_q  (sticky_q),
        .prio_q    (prio_q)
    );

    for (genvar g = 0; g < NUM_BANK; g++) begin : g_bank
        intc_bank u_bank (
            .clk    (clk),
            .rst    (rst),
            .ctl    (ctl[g]),
            .wdata  (wdata),
            .cond   (cond),
            .sticky (sticky_q),
            .prio   (prio_q),
            .en_q   (en_q[g]),
            .thr_q  (thr_q[g]),
            .masked (masked[g]),
            .cur    (cur[g]),
            .req    (req[g])
        );
    end

    always_comb begin
        rdata = '0;
        if (!in_shared) begin
            case (ofs)
                REG_MASKED:  rdata = DATA_W'(masked[bank_sel]);
                REG_RAW:     rdata = DATA_W'(cond);
                REG_EN_SET:  rdata = DATA_W'(en_q[bank_sel]);
                REG_CURRENT: rdata = DATA_W'(cur[bank_sel]);
                REG_THRESH:  rdata = DATA_W'(thr_q[bank_sel]);
                default:     rdata = '0;
            endcase
        end else if (!bank_sel) begin
            if (ofs == SH_POLARITY)    rdata = DATA_W'(pol_q);
            else if (ofs == SH_STICKY) rdata = DATA_W'(sticky_q);
        end else if (prio_hit) begin
            rdata = DATA_W'(prio_q[prio_idx]);
        end
    end

    assign irq_o = req[0];
    assign fiq_o = req[1];
endmodule

// File: tb/test_intc_dual.sv
module test_intc_dual;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] rdata;
    logic [31:0] src_i = '0;
    logic        irq_o, fiq_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    intc_dual i_intc_dual (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .rdata(rdata), .src_i(src_i), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    typedef struct packed {
        logic [31:0] lines;
        logic [3:0]  thr;
        logic [31:0] status;
        logic [4:0]  current;
    } vec_t;

    // Priorities used by the table: line 5 -> 3, lines 9 and 20 -> 1, line 31 -> 0xE, all others 0.
    localparam vec_t VECS [10] = '{
        '{32'h0000_0000, 4'hF, 32'h0000_0000, 5'd0},
        '{32'h0000_0020, 4'hF, 32'h0000_0020, 5'd5},
        '{32'h0000_0220, 4'hF, 32'h0000_0220, 5'd9},
        '{32'h0010_0200, 4'hF, 32'h0010_0200, 5'd9},
        '{32'h8010_0000, 4'hF, 32'h8010_0000, 5'd20},
        '{32'h8000_0000, 4'hD, 32'h0000_0000, 5'd0},
        '{32'h8000_0020, 4'h2, 32'h0000_0000, 5'd0},
        '{32'h0000_0021, 4'h2, 32'h0000_0001, 5'd0},
        '{32'hFFFF_FFFF, 4'h0, 32'h7FEF_FDDF, 5'd0},
        '{32'h8010_0220, 4'hF, 32'h8010_0220, 5'd9}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(posedge clk);
        #1 rd_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [9:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic set_lines(input logic [31:0] v);
        @(negedge clk);
        src_i = v;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        @(negedge clk); #1;
        check("R1 irq_o", {31'b0, irq_o}, 0);
        check("R1 fiq_o", {31'b0, fiq_o}, 0);
        rd_chk("R1 irq thr", 10'h02C, 32'hF);
        rd_chk("R1 fiq thr", 10'h12C, 32'hF);
        rd_chk("R1 irq enable", 10'h008, 0);
        rd_chk("R1 fiq enable", 10'h108, 0);
        rd_chk("R1 irq current", 10'h020, 0);
        rd_chk("R1 prio 7", 10'h31C, 0);

        // R3: polarity resets to invert; mixed polarity
        rd_chk("R3 raw inverted", 10'h004, 32'hFFFF_FFFF);
        rd_chk("R3 raw inverted fiq view", 10'h104, 32'hFFFF_FFFF);
        wr(10'h200, 32'h0000_000F);
        set_lines(32'h0000_00A5);
        rd_chk("R3 raw mixed", 10'h004, 32'hFFFF_FF55);
        rd_chk("R3 polarity readback", 10'h200, 32'h0000_000F);
        wr(10'h200, 32'hFFFF_FFFF);
        rd_chk("R3 raw uninverted", 10'h004, 32'h0000_00A5);
        set_lines(0);
        rd_chk("R3 raw idle", 10'h004, 0);

        // R2: enable set / clear
        wr(10'h008, 32'h0000_00F0);
        rd_chk("R2 set", 10'h008, 32'h0000_00F0);
        wr(10'h008, 32'h0000_0003);
        rd_chk("R2 set accumulates", 10'h008, 32'h0000_00F3);
        wr(10'h00C, 32'h0000_0011);
        rd_chk("R2 clear", 10'h008, 32'h0000_00E2);
        rd_chk("R2 clear offset reads 0", 10'h00C, 0);
        rd_chk("R2 other bank untouched", 10'h108, 0);
        wr(10'h00C, 32'hFFFF_FFFF);
        rd_chk("R2 clear all", 10'h008, 0);

        // R9: priority table
        wr(10'h314, 32'h3);
        wr(10'h324, 32'h1);
        wr(10'h350, 32'h1);
        wr(10'h37C, 32'hFFFF_FFFE);
        rd_chk("R9 prio 31 truncated", 10'h37C, 32'hE);
        rd_chk("R9 prio 5", 10'h314, 32'h3);

        // R4 R7 R8: table walk on the normal bank
        wr(10'h008, 32'hFFFF_FFFF);
        foreach (VECS[i]) begin
            wr(10'h02C, {28'b0, VECS[i].thr});
            set_lines(VECS[i].lines);
            rd_chk($sformatf("R4 status vec %0d", i), 10'h000, VECS[i].status);
            rd_chk($sformatf("R7 R8 current vec %0d", i), 10'h020, {27'b0, VECS[i].current});
            check($sformatf("R4 irq_o vec %0d", i), {31'b0, irq_o}, {31'b0, VECS[i].status != 0});
            check($sformatf("R4 fiq_o idle vec %0d", i), {31'b0, fiq_o}, 0);
        end
        wr(10'h00C, 32'hFFFF_FFFF);
        wr(10'h02C, 32'hF);
        set_lines(0);

        // R5 R6: sticky line 3, plain line 4, both banks
        wr(10'h204, 32'h0000_0008);
        wr(10'h008, 32'h0000_0018);
        wr(10'h108, 32'h0000_0018);
        set_lines(32'h0000_0018);
        set_lines(0);
        rd_chk("R6 raw after pulse", 10'h004, 0);
        rd_chk("R5 R6 irq status held", 10'h000, 32'h8);
        rd_chk("R5 fiq status held", 10'h100, 32'h8);
        rd_chk("R7 current sticky", 10'h020, 32'd3);
        check("R5 irq_o held", {31'b0, irq_o}, 1);
        rd_chk("R5 ack irq", 10'h028, 0);
        rd_chk("R5 irq released", 10'h000, 0);
        rd_chk("R5 fiq still held", 10'h100, 32'h8);
        @(negedge clk); #1;
        check("R5 irq_o low", {31'b0, irq_o}, 0);
        check("R5 fiq_o high", {31'b0, fiq_o}, 1);
        rd_chk("R5 ack fiq", 10'h128, 0);
        rd_chk("R5 fiq released", 10'h100, 0);
        @(negedge clk); #1;
        check("R5 fiq_o low", {31'b0, fiq_o}, 0);

        finish_run();
    end
endmodule